// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a synchronous serial link built from three wires: a frame line, a serial clock and one data line that can be driven either way. Through it a host reads and writes a small file of byte-wide registers. Each frame opens with a command byte that gives the access direction, a register address and a burst selector. Data bytes follow the command. All bits travel least significant bit first. The block samples incoming bits on rising serial-clock edges and changes outgoing bits on falling edges.

The serial clock and the frame line are much slower than the system clock. They are synchronised into the system clock domain, and their edges are detected there. The data line is split into an input, an output and an output enable, which the pad ring joins into one bidirectional pin. The highest register holds a write-protect flag. When this flag is set, the other registers cannot be changed from the link.

Top module: `regport_top`

## Requirements
- R1: While the frame line is low, the output enable is low and any transfer in progress is abandoned. After system reset the output enable and the data output are both 0.
- R2: The first 8 rising serial-clock edges of a frame carry the command byte, bit 0 first. Command bit 0 selects the direction (1 = read, 0 = write), and bits 3:1 give the register address.
- R3: If command bit 7 is 0, the data bytes of a write frame change no register. A read frame with command bit 7 at 0 still returns the register contents.
- R4: On a read, each data bit changes only after a falling serial-clock edge. The first data bit appears after the falling edge that follows the 8th command bit. The output enable goes high on that edge and stays high until the frame line falls. It never goes high in a write frame.
- R5: Data bytes are shifted least significant bit first in both directions. A written byte reaches its register on the rising edge that carries its 8th bit.
- R6: When command bits 6:4 are 111, the frame is a burst. The address field is ignored, bytes go to or come from registers 0, 1, … 7 in that order, and clocks after the byte of register 7 are ignored.
- R7: Bit 7 of register 7 is a write-protect flag. While it is 1, writes to registers 0 to 6 are ignored, and register 7 itself stays writable.
- R8: A write byte whose 8 bits are not all received before the frame line falls changes no register.
- R9: In a non-burst frame only one data byte is transferred. Further clocks in the same frame change no register.
- R10: System reset clears all eight registers to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous system reset |
| ssEn | input | 1 | Frame line; high for the whole transfer |
| sClk | input | 1 | Serial clock from the host |
| sDataIn | input | 1 | Data line as seen by the block |
| sDataOut | output | 1 | Data bit driven toward the host on reads |
| sDataOe | output | 1 | Output enable for the data line pad |

## Verification
The bench uses bytes whose bit patterns are not symmetric. A design that shifts most significant bit first, or samples on the wrong edge, returns a bit-reversed or shifted value. It cuts a write off after five bits and sends a second byte in a single-mode frame. A design that commits a byte early, or keeps advancing the address, corrupts a register that is read back afterwards. Bursts are run with an address field that should be ignored, with a ninth byte past the end, and with write protection set. A wrong start address, wrap-around, or a protect check that also locks register 7 each shows up as a wrong byte on read-back. Write frames with command bit 7 cleared, and the output enable during and after read and write frames, are checked too.

// File: rtl/regport_pkg.sv
package regport_pkg;

  // Command byte layout (bit positions decoded by the control unit)
  localparam int CMD_RW_BIT   = 0;
  localparam int CMD_ADDR_LO  = 1;
  localparam int CMD_MODE_LO  = 4;
  localparam int CMD_MODE_HI  = 6;
  localparam int CMD_WEN_BIT  = 7;
  localparam int PROTECT_BIT  = 7;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_XFER,
    PH_DONE
  } phase_e;

  // Strobes from control to datapath, at most one shift/load per cycle
  typedef struct packed {
    logic loadRd;
    logic shiftRd;
    logic shiftWr;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enLvl,
  input  logic              sclkLvl,
  input  logic              inBit,
  input  logic              wpFlag,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] regAddr,
  output logic              oe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] cmdSr;
  logic [DATA_W-1:0] cmdNext;
  logic [ADDR_W-1:0] curAddr;
  logic              isRead;
  logic              isBurst;
  logic              wrOk;
  logic              pendLoad;
  logic              sclkPrev;
  logic              sclkRise;
  logic              sclkFall;
  logic              burstCmd;
  logic              byteEnd;
  logic              lastAddr;

  assign sclkRise = sclkLvl & ~sclkPrev;
  assign sclkFall = ~sclkLvl & sclkPrev;
  assign cmdNext  = {inBit, cmdSr[DATA_W-1:1]};
  assign burstCmd = &cmdNext[CMD_MODE_HI:CMD_MODE_LO];
  assign byteEnd  = (bitCnt == LAST_BIT);
  assign lastAddr = (curAddr == TOP_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      cmdSr    <= '0;
      curAddr  <= '0;
      isRead   <= 1'b0;
      isBurst  <= 1'b0;
      wrOk     <= 1'b0;
      pendLoad <= 1'b0;
      oe       <= 1'b0;
    end else if (!enLvl) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      pendLoad <= 1'b0;
      oe       <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase  <= PH_CMD;
          bitCnt <= '0;
        end
        PH_CMD: begin
          if (sclkRise) begin
            cmdSr  <= cmdNext;
            bitCnt <= byteEnd ? '0 : bitCnt + 1'b1;
            if (byteEnd) begin
              curAddr  <= burstCmd ? '0 : cmdNext[CMD_ADDR_LO +: ADDR_W];
              isRead   <= cmdNext[CMD_RW_BIT];
              isBurst  <= burstCmd;
              wrOk     <= cmdNext[CMD_WEN_BIT];
              pendLoad <= cmdNext[CMD_RW_BIT];
              phase    <= PH_XFER;
            end
          end
        end
        PH_XFER: begin
          if (pendLoad) pendLoad <= 1'b0;
          if ((isRead && sclkFall) || (!isRead && sclkRise)) begin
            if (isRead) oe <= 1'b1;
            bitCnt <= byteEnd ? '0 : bitCnt + 1'b1;
            if (byteEnd) begin
              if (isBurst && !lastAddr) begin
                curAddr  <= curAddr + 1'b1;
                pendLoad <= isRead;
              end else begin
                phase <= PH_DONE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.loadRd  = enLvl && (phase == PH_XFER) && pendLoad;
    strb.shiftRd = enLvl && (phase == PH_XFER) && isRead && sclkFall;
    strb.shiftWr = enLvl && (phase == PH_XFER) && !isRead && sclkRise;
    strb.commit  = strb.shiftWr && byteEnd && wrOk
                   && (!wpFlag || lastAddr);
  end

  assign regAddr = curAddr;

endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              inBit,
  output logic              outBit,
  output logic              wpFlag
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rdSr;
  logic [DATA_W-1:0] wrSr;
  logic [DATA_W-1:0] wrNext;

  assign wrNext = {inBit, wrSr[DATA_W-1:1]};
  assign wpFlag = regs[NUM_REGS-1][PROTECT_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSr   <= '0;
      outBit <= 1'b0;
    end else if (strb.loadRd) begin
      rdSr <= regs[regAddr];
    end else if (strb.shiftRd) begin
      outBit <= rdSr[0];
      rdSr   <= rdSr >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             wrSr <= '0;
    else if (strb.shiftWr) wrSr <= wrNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strb.commit) begin
      regs[regAddr] <= wrNext;
    end
  end

endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ssEn,
  input  logic sClk,
  input  logic sDataIn,
  output logic sDataOut,
  output logic sDataOe
);

  logic [2:0]        syncOut;
  logic              enLvl;
  logic              sclkLvl;
  logic              inBit;
  logic              wpFlag;
  logic [ADDR_W-1:0] regAddr;
  dpStrobe_t         strb;

  regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({ssEn, sClk, sDataIn}),
    .dout (syncOut)
  );

  assign {enLvl, sclkLvl, inBit} = syncOut;

  regport_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enLvl   (enLvl),
    .sclkLvl (sclkLvl),
    .inBit   (inBit),
    .wpFlag  (wpFlag),
    .strb    (strb),
    .regAddr (regAddr),
    .oe      (sDataOe)
  );

  regport_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regAddr (regAddr),
    .inBit   (inBit),
    .outBit  (sDataOut),
    .wpFlag  (wpFlag)
  );

endmodule

// File: rtl/regport_chk.sv
module regport_chk
  import regport_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              enLvl,
  input logic              sclkLvl,
  input dpStrobe_t         strb,
  input logic              wpFlag,
  input logic [ADDR_W-1:0] regAddr,
  input logic              oe,
  input logic              dOut
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !enLvl |=> !oe); // R1

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |-> ($past(sclkLvl, 2) && !$past(sclkLvl))); // R4

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (dOut != $past(dOut)) |-> ($past(sclkLvl, 2) && !$past(sclkLvl))); // R4

  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (sclkLvl && !$past(sclkLvl))); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.loadRd, strb.shiftRd, strb.shiftWr}) <= 1); // R5

  AST_PROTECT_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && wpFlag) |-> (regAddr == CTRL_ADDR)); // R7

endmodule

bind regport_top regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enLvl   (enLvl),
  .sclkLvl (sclkLvl),
  .strb    (strb),
  .wpFlag  (wpFlag),
  .regAddr (regAddr),
  .oe      (sDataOe),
  .dOut    (sDataOut)
);

// File: tb/regport_top_tb.sv
module regport_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NVEC       = 9;

  // {isWrite, addr, writeData, expectedRead}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 8'h59, 8'h00},
    {1'b1, 3'd3, 8'h31, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h59},
    {1'b0, 3'd3, 8'h00, 8'h31},
    {1'b1, 3'd5, 8'hA6, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'hA6},
    {1'b1, 3'd0, 8'h00, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ssEn = 1'b0;
  logic sClk = 1'b0;
  logic sDataIn = 1'b0;
  logic sDataOut;
  logic sDataOe;

  int   nChk = 0;
  int   nBad = 0;
  bit   finished = 1'b0;
  logic [7:0] got;
  logic       oeAll;

  always #(CLK_PERIOD/2) clk = ~clk;

  regport_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .ssEn     (ssEn),
    .sClk     (sClk),
    .sDataIn  (sDataIn),
    .sDataOut (sDataOut),
    .sDataOe  (sDataOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sDataIn = b[i];
      waitClk(HALF);
      sClk = 1'b1;
      waitClk(HALF);
      sClk = 1'b0;
    end
  endtask

  task automatic recvByte(output logic [7:0] b, output logic oeHigh);
    oeHigh = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitClk(HALF);
      b[i] = sDataOut;
      oeHigh &= sDataOe;
      sClk = 1'b1;
      waitClk(HALF);
      sClk = 1'b0;
    end
  endtask

  task automatic startFrame();
    ssEn = 1'b1;
    waitClk(6);
  endtask

  task automatic endFrame();
    waitClk(HALF);
    ssEn = 1'b0;
    waitClk(8);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    startFrame();
    sendBits({1'b1, 3'b000, a, 1'b0}, 8);
    sendBits(d, 8);
    endFrame();
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    logic oeTmp;
    startFrame();
    sendBits({1'b1, 3'b000, a, 1'b1}, 8);
    recvByte(d, oeTmp);
    endFrame();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1 reset state at the ports
    check("R1 reset oe", {7'b0, sDataOe}, 8'h00);
    check("R1 reset out", {7'b0, sDataOut}, 8'h00);
    // R10 registers cleared by reset
    readReg(3'd6, got);
    check("R10 reset register", got, 8'h00);

    // R2 R5 table of single-byte accesses
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][19]) begin
        writeReg(VEC[k][18:16], VEC[k][15:8]);
      end else begin
        readReg(VEC[k][18:16], got);
        check("R2/R5 table read", got, VEC[k][7:0]);
      end
    end

    // R4 output enable held through a read, R1 released at frame end
    startFrame();
    sendBits(8'h87, 8);
    recvByte(got, oeAll);
    check("R4 oe during read", {7'b0, oeAll}, 8'h01);
    check("R4 read data", got, 8'h31);
    endFrame();
    check("R1 oe after frame", {7'b0, sDataOe}, 8'h00);

    // R4 output enable stays low in a write frame
    startFrame();
    sendBits(8'h86, 8);
    sendBits(8'h31, 8);
    check("R4 oe in write", {7'b0, sDataOe}, 8'h00);
    endFrame();

    // R3 write with bit 7 clear ignored, read with bit 7 clear allowed
    startFrame();
    sendBits(8'h06, 8);
    sendBits(8'hEE, 8);
    endFrame();
    startFrame();
    sendBits(8'h07, 8);
    recvByte(got, oeAll);
    endFrame();
    check("R3 write disabled", got, 8'h31);

    // R8 partial byte discarded
    startFrame();
    sendBits(8'h86, 8);
    sendBits(8'hFF, 5);
    endFrame();
    readReg(3'd3, got);
    check("R8 partial write", got, 8'h31);

    // R9 second byte in single mode ignored
    startFrame();
    sendBits(8'h88, 8);
    sendBits(8'h3C, 8);
    sendBits(8'hC3, 8);
    endFrame();
    readReg(3'd4, got);
    check("R9 first byte kept", got, 8'h3C);
    readReg(3'd5, got);
    check("R9 next register untouched", got, 8'hA6);

    // R6 burst write with address field 7 (ignored) and a 9th byte
    startFrame();
    sendBits(8'hFE, 8);
    for (int i = 0; i < 7; i++) sendBits(8'h10 + 8'(i), 8);
    sendBits(8'h00, 8);
    sendBits(8'h99, 8);
    endFrame();
    startFrame();
    sendBits(8'hFF, 8);
    for (int i = 0; i < 8; i++) begin
      recvByte(got, oeAll);
      check("R6 burst read", got, (i == 7) ? 8'h00 : 8'h10 + 8'(i));
    end
    endFrame();
    readReg(3'd0, got);
    check("R6 no wrap after register 7", got, 8'h10);

    // R7 write protect
    writeReg(3'd7, 8'h80);
    writeReg(3'd2, 8'h55);
    readReg(3'd2, got);
    check("R7 protected write", got, 8'h12);
    readReg(3'd7, got);
    check("R7 control readable", got, 8'h80);
    startFrame();
    sendBits(8'hFE, 8);
    for (int i = 0; i < 7; i++) sendBits(8'h20 + 8'(i), 8);
    sendBits(8'h81, 8);
    endFrame();
    readReg(3'd0, got);
    check("R7 burst protected", got, 8'h10);
    readReg(3'd7, got);
    check("R7 control writable", got, 8'h81);
    writeReg(3'd7, 8'h00);
    writeReg(3'd2, 8'h55);
    readReg(3'd2, got);
    check("R7 unprotected write", got, 8'h55);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule